// File: doc/BRIEF.md
# Global Output Disable Controller

This block produces the device-wide test signal that takes every user output off the pins. While the signal is active, each user I/O output buffer is driven to high impedance with its pull-up forced on and its pull-down blocked. The test data output buffer is also released, and the DONE pin is released with its pull-up enabled. Board-level test uses this to isolate the device without disturbing its configuration.

Where the request comes from depends on the configuration phase. Before configuration and while it runs, the dedicated pad is the only source and it is read as active-low. Once configuration is complete, a two-bit source field picks nothing, the dedicated pad or a general routing signal, and a polarity bit sets the active level. Both asynchronous request inputs pass through a synchronizer before they are used. All of the forced controls leave the block from registers.

Top module: `gout_disable_ctrl`

## Requirements
- R1: While `cfg_done` is 0, the disable follows only the dedicated pad. `src_sel`, `invert` and `route_in` have no effect on any output.
- R2: While `cfg_done` is 0, the pad is active-low: pad 0 forces the outputs and pad 1 releases them.
- R3: With `cfg_done` = 1 and `src_sel` equal to 0 or 3 (source off), no output is forced, whatever the pad, routing and polarity inputs are.
- R4: With `cfg_done` = 1, `src_sel` = 1 takes the request from the pad and `src_sel` = 2 takes it from `route_in`. The other input is ignored.
- R5: With `cfg_done` = 1, `invert` = 0 makes the selected input active-low and `invert` = 1 makes it active-high.
- R6: While the disable is active, every bit of `uio_tri_force`, `uio_pu_force` and `uio_pd_block` is 1. Otherwise every bit is 0.
- R7: `tdo_tri_force` is 1 exactly while the disable is active.
- R8: `done_tri_force` and `done_pu_force` are both 1 exactly while the disable is active.
- R9: A change on `pad_in` or `route_in` reaches the outputs on the (SYNC_STAGES+1)th rising edge after it. A change on `cfg_done`, `src_sel` or `invert` reaches them on the first rising edge.
- R10: `rst` is synchronous and active-high. The rising edge that samples it clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | 1 once configuration is complete |
| pad_in | input | 1 | Dedicated pad request, asynchronous |
| route_in | input | 1 | General routing request, asynchronous |
| src_sel | input | 2 | Source after configuration: 0/3 off, 1 pad, 2 routing |
| invert | input | 1 | Polarity after configuration: 0 active-low, 1 active-high |
| uio_tri_force | output | N_IO | Per user pin: force output buffer to high impedance |
| uio_pu_force | output | N_IO | Per user pin: force input pull-up on |
| uio_pd_block | output | N_IO | Per user pin: force input pull-down off |
| tdo_tri_force | output | 1 | Force test data output to high impedance |
| done_tri_force | output | 1 | Force DONE output to high impedance |
| done_pu_force | output | 1 | Force DONE input pull-up on |

## Verification
The bench builds the block with N_IO = 4 and SYNC_STAGES = 2. That is small enough to sweep all 64 combinations of phase, source field, polarity, pad level and routing level, and to check every pin vector against an all-zeros or all-ones value. Each combination is held for SYNC_STAGES+1 edges, so the full synchronizer depth is exercised. Separate cases step the pad and the phase bit, then sample one edge short of the stated latency and again at it. They also check that the reset edge clears a forced state.

// File: rtl/god_pkg.sv
package god_pkg;

  // Source field encoding used once configuration is complete
  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_PAD   = 2'd1,
    SRC_ROUTE = 2'd2,
    SRC_NONE  = 2'd3
  } god_src_e;

  localparam int SRC_W = 2;

endpackage

// File: rtl/god_sync.sv
module god_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/god_src_mux.sv
module god_src_mux
  import god_pkg::*;
(
  input  logic             cfg_done,
  input  logic             pad_s,
  input  logic             route_s,
  input  logic [SRC_W-1:0] src_sel,
  input  logic             invert,
  output logic             dis_act
);

  god_src_e src;
  logic     raw;
  logic     use_src;

  always_comb begin
    src     = god_src_e'(src_sel);
    raw     = 1'b1;
    use_src = 1'b0;
    unique case (src)
      SRC_PAD:   begin raw = pad_s;   use_src = 1'b1; end
      SRC_ROUTE: begin raw = route_s; use_src = 1'b1; end
      default:   begin raw = 1'b1;    use_src = 1'b0; end
    endcase

    if (!cfg_done)
      dis_act = ~pad_s;                          // fixed pad, active-low
    else if (use_src)
      dis_act = invert ? raw : ~raw;             // programmable sense
    else
      dis_act = 1'b0;                            // source off
  end

endmodule

// File: rtl/god_force_gen.sv
module god_force_gen #(
  parameter int N_IO = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dis_act,
  output logic [N_IO-1:0] uio_tri_force,
  output logic [N_IO-1:0] uio_pu_force,
  output logic [N_IO-1:0] uio_pd_block,
  output logic            tdo_tri_force,
  output logic            done_tri_force,
  output logic            done_pu_force
);

  // One register per pin control so each output can sit near its pad
  generate
    for (genvar p = 0; p < N_IO; p++) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst) begin
          uio_tri_force[p] <= 1'b0;
          uio_pu_force[p]  <= 1'b0;
          uio_pd_block[p]  <= 1'b0;
        end else begin
          uio_tri_force[p] <= dis_act;
          uio_pu_force[p]  <= dis_act;
          uio_pd_block[p]  <= dis_act;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tdo_tri_force  <= 1'b0;
      done_tri_force <= 1'b0;
      done_pu_force  <= 1'b0;
    end else begin
      tdo_tri_force  <= dis_act;
      done_tri_force <= dis_act;
      done_pu_force  <= dis_act;
    end
  end

endmodule

// File: rtl/gout_disable_ctrl.sv
module gout_disable_ctrl
  import god_pkg::*;
#(
  parameter int N_IO        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_done,
  input  logic             pad_in,
  input  logic             route_in,
  input  logic [SRC_W-1:0] src_sel,
  input  logic             invert,
  output logic [N_IO-1:0]  uio_tri_force,
  output logic [N_IO-1:0]  uio_pu_force,
  output logic [N_IO-1:0]  uio_pd_block,
  output logic             tdo_tri_force,
  output logic             done_tri_force,
  output logic             done_pu_force
);

  logic pad_s;
  logic route_s;
  logic dis_act;

  // Idle level of both request lines is high (inactive for active-low)
  god_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pad (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pad_in),
    .d_out (pad_s)
  );

  god_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_route (
    .clk   (clk),
    .rst   (rst),
    .d_in  (route_in),
    .d_out (route_s)
  );

  god_src_mux u_mux (
    .cfg_done (cfg_done),
    .pad_s    (pad_s),
    .route_s  (route_s),
    .src_sel  (src_sel),
    .invert   (invert),
    .dis_act  (dis_act)
  );

  god_force_gen #(.N_IO(N_IO)) u_force (
    .clk            (clk),
    .rst            (rst),
    .dis_act        (dis_act),
    .uio_tri_force  (uio_tri_force),
    .uio_pu_force   (uio_pu_force),
    .uio_pd_block   (uio_pd_block),
    .tdo_tri_force  (tdo_tri_force),
    .done_tri_force (done_tri_force),
    .done_pu_force  (done_pu_force)
  );

endmodule

// File: rtl/god_checker.sv
module god_checker #(
  parameter int N_IO        = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_done,
  input logic            pad_in,
  input logic            route_in,
  input logic [1:0]      src_sel,
  input logic            invert,
  input logic [N_IO-1:0] uio_tri_force,
  input logic [N_IO-1:0] uio_pu_force,
  input logic [N_IO-1:0] uio_pd_block,
  input logic            tdo_tri_force,
  input logic            done_tri_force,
  input logic            done_pu_force
);

  localparam int CW = $clog2(SYNC_STAGES + 2) + 1;
  localparam logic [CW-1:0] VALID_AT = CW'(SYNC_STAGES + 1);

  logic [SYNC_STAGES:0] pad_h;
  logic [SYNC_STAGES:0] route_h;
  logic [CW-1:0]        since_rst;
  logic                 hist_ok;

  always_ff @(posedge clk) begin
    pad_h   <= {pad_h[SYNC_STAGES-1:0], pad_in};
    route_h <= {route_h[SYNC_STAGES-1:0], route_in};
    if (rst)                       since_rst <= '0;
    else if (since_rst < VALID_AT) since_rst <= since_rst + 1'b1;
  end

  assign hist_ok = (since_rst >= VALID_AT);

  AST_PRECFG_PAD: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && !$past(cfg_done)) |-> (done_tri_force == !pad_h[SYNC_STAGES])); // R1

  AST_SRC_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cfg_done && (src_sel == 2'd0 || src_sel == 2'd3)) |=> (uio_tri_force == '0)); // R3

  AST_ROUTE_SENSE: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(cfg_done) && $past(src_sel) == 2'd2) |->
      (done_tri_force == ($past(invert) ? route_h[SYNC_STAGES] : !route_h[SYNC_STAGES]))); // R5

  AST_PINS_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    ((uio_tri_force == '0 || uio_tri_force == '1) &&
     uio_pu_force == uio_tri_force && uio_pd_block == uio_tri_force)); // R6

  AST_TDO_MATCH: assert property (@(posedge clk) disable iff (rst)
    tdo_tri_force == uio_tri_force[0]); // R7

  AST_DONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (done_tri_force == tdo_tri_force) && (done_pu_force == done_tri_force)); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!done_tri_force && !tdo_tri_force && uio_tri_force == '0)); // R10

endmodule

bind gout_disable_ctrl god_checker #(.N_IO(N_IO), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/gout_disable_ctrl_tb.sv
module gout_disable_ctrl_tb;

  localparam int N_IO = 4;
  localparam int SS   = 2;

  logic            clk = 1'b0;
  logic            rst;
  logic            cfg_done;
  logic            pad_in;
  logic            route_in;
  logic [1:0]      src_sel;
  logic            invert;
  logic [N_IO-1:0] uio_tri_force;
  logic [N_IO-1:0] uio_pu_force;
  logic [N_IO-1:0] uio_pd_block;
  logic            tdo_tri_force;
  logic            done_tri_force;
  logic            done_pu_force;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  gout_disable_ctrl #(.N_IO(N_IO), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .pad_in(pad_in),
    .route_in(route_in), .src_sel(src_sel), .invert(invert),
    .uio_tri_force(uio_tri_force), .uio_pu_force(uio_pu_force),
    .uio_pd_block(uio_pd_block), .tdo_tri_force(tdo_tri_force),
    .done_tri_force(done_tri_force), .done_pu_force(done_pu_force)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic model(input logic c, input logic [1:0] s, input logic inv,
                                 input logic p, input logic r);
    if (!c)            return !p;
    else if (s == 2'd1) return inv ? p : !p;
    else if (s == 2'd2) return inv ? r : !r;
    else               return 1'b0;
  endfunction

  task automatic chk_all(input string req, input logic e);
    logic [31:0] vec;
    vec = e ? 32'((1 << N_IO) - 1) : 32'd0;
    chk({req, " R6 tri"}, 32'(uio_tri_force), vec);
    chk({req, " R6 pu"},  32'(uio_pu_force),  vec);
    chk({req, " R6 pd"},  32'(uio_pd_block),  vec);
    chk({req, " R7 tdo"}, 32'(tdo_tri_force), 32'(e));
    chk({req, " R8 done"}, 32'({done_tri_force, done_pu_force}), {30'd0, e, e});
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; cfg_done = 1'b0; pad_in = 1'b1; route_in = 1'b1;
    src_sel = 2'd0; invert = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_all("R10 reset", 1'b0);
    rst = 1'b0;

    // Full sweep of phase, source, polarity, pad and routing
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 2; v++)
          for (int p = 0; p < 2; p++)
            for (int r = 0; r < 2; r++) begin
              string tag;
              @(negedge clk);
              cfg_done = c[0]; src_sel = s[1:0]; invert = v[0];
              pad_in = p[0]; route_in = r[0];
              repeat (SS + 1) @(posedge clk);
              @(negedge clk);
              if (c == 0)                  tag = "R1 R2";
              else if (s == 0 || s == 3)   tag = "R3";
              else                         tag = "R4 R5";
              chk_all(tag, model(c[0], s[1:0], v[0], p[0], r[0]));
            end

    // Pad latency: one edge short, then at the stated edge
    @(negedge clk);
    cfg_done = 1'b0; pad_in = 1'b1;
    repeat (SS + 2) @(posedge clk);
    @(negedge clk);
    pad_in = 1'b0;
    repeat (SS) @(posedge clk);
    @(negedge clk);
    chk("R9 pad early", 32'(done_tri_force), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 pad on time", 32'(done_tri_force), 32'd1);

    // Phase bit latency: one edge
    cfg_done = 1'b1; src_sel = 2'd0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 cfg one edge", 32'(tdo_tri_force), 32'd0);

    // Routing latency after configuration, active-high
    src_sel = 2'd2; invert = 1'b1; route_in = 1'b0;
    repeat (SS + 2) @(posedge clk);
    @(negedge clk);
    route_in = 1'b1;
    repeat (SS) @(posedge clk);
    @(negedge clk);
    chk("R9 route early", 32'(done_tri_force), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 route on time", 32'(done_tri_force), 32'd1);

    // Reset edge clears a forced state
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_all("R10 reset forced", 1'b0);
    rst = 1'b0;

    finish_run();
  end

endmodule